// File: doc/BRIEF.md
# Sector Buffer Write Sequencer

This block receives one CD sector at a time as a byte stream, a 4-byte header followed by 2048 data bytes, and lays it into a 16 KiB circular byte buffer. A decode-enable control bit gates all activity. When that bit is set, the four header bytes are latched into the current-header register. The valid-status byte is driven to its "new sector" value, and the decoder-pending flag, which is active low, is asserted.

A buffer-write request bit is sampled when the first header byte is taken. When the bit is set, the block pointer and the write address each advance by the raw sector length of 2352. The sector is then stored at the new block pointer masked to 14 bits, and the storage address wraps at the buffer end. When the bit is clear, only the header is taken. A one-cycle done pulse with a cleared consumed flag then tells the source to present the same sector again.

The register block around this sequencer loads both pointers, acknowledges the status after reading it, and reads stored bytes back through a byte-wide read port with one cycle of latency.

Top module: `sector_buf_writer`

## Requirements
- R1: After reset: `cur_hdr` = 32'h0000_0001, `valid_stat` = 8'h80, `dec_pend_n` = 1, `blk_ptr` = `wr_addr` = 0, `done` = 0, and `s_ready` = 0 while `dec_en` is low.
- R2: While `dec_en` is low and no sector is in its data phase, `s_ready` stays low and offered bytes change neither the header, the pointers nor the status.
- R3: The edge that takes the fourth header byte loads `cur_hdr` with the header bytes, first byte in bits 31:24 and fourth in bits 7:0. The same edge sets `valid_stat` to 8'h00 and `dec_pend_n` to 0.
- R4: If `wr_req` is high when the first header byte is taken, `blk_ptr` and `wr_addr` each grow by 2352 at that edge. Otherwise both are left unchanged.
- R5: A stored sector occupies 2052 consecutive buffer bytes: header bytes first, then data. Storage starts at the new `blk_ptr` AND 14'h3FFF, and addresses past 14'h3FFF continue at 0.
- R6: With `wr_req` low at the first header byte, only the 4 header bytes are taken. `done` pulses with `consumed` = 0 in the cycle after the fourth byte, and no buffer byte is written.
- R7: After the 2052nd byte of a stored sector is taken, `done` is high with `consumed` = 1 for exactly one cycle, in the next cycle.
- R8: `stat_ack` returns `valid_stat` to 8'h80 and `dec_pend_n` to 1 at the next edge. A header completion at the same edge takes priority.
- R9: `ld_ptrs` loads `blk_ptr` and `wr_addr` from `ld_blk_ptr` and `ld_wr_addr` at the next edge. A simultaneous advance from R4 takes priority.
- R10: `rd_data` shows the buffer byte at `rd_addr` one cycle after the address is presented.
- R11: Once a sector is in its data phase, `s_ready` stays high whatever `dec_en` does, until the last byte.
- R12: `blk_ptr` and `wr_addr` wrap modulo 65536 when they advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dec_en | input | 1 | Decode enable control bit |
| wr_req | input | 1 | Buffer write request control bit |
| s_valid | input | 1 | Sector byte valid |
| s_data | input | 8 | Sector byte |
| s_ready | output | 1 | Sector byte accepted when high with `s_valid` |
| ld_ptrs | input | 1 | Load both pointers |
| ld_blk_ptr | input | 16 | Block pointer load value |
| ld_wr_addr | input | 16 | Write address load value |
| stat_ack | input | 1 | Status read acknowledge |
| done | output | 1 | One-cycle end-of-sector pulse |
| consumed | output | 1 | Qualifies `done`: 1 = sector stored, 0 = present again |
| cur_hdr | output | 32 | Current header, first byte in 31:24 |
| blk_ptr | output | 16 | Block pointer |
| wr_addr | output | 16 | Write address |
| valid_stat | output | 8 | Valid status: 8'h00 new sector, 8'h80 idle |
| dec_pend_n | output | 1 | Decoder pending flag, active low |
| rd_addr | input | 14 | Buffer read address |
| rd_data | output | 8 | Buffer read data, one cycle latency |

## Verification
A byte counter that is off by one shows up in the cycle after the sector ends. The done pulse comes early or late, and the last data byte is missing or lands one address past the 2052-byte region, which a full readback of that region catches. A stale latched write-request decision shows up one edge after the first header byte as a wrong pointer value. A wrong base offset shows up in the readback, including the regions that straddle the buffer end. A wrong status priority is visible in `valid_stat` in the very cycle after the header ends.

// File: rtl/sbw_pkg.sv
// Package: shared sizes and the phase type for the sector buffer writer.
// Assumes byte-wide input and a power-of-two buffer split into byte lanes.
package sbw_pkg;
    localparam int HDR_BYTES  = 4;
    localparam int DATA_BYTES = 2048;
    localparam int RAW_STEP   = 2352;
    localparam int BUF_AW     = 14;
    localparam int PTR_W      = 16;
    localparam int LANES      = 4;

    typedef enum logic {
        PH_HDR  = 1'b0,
        PH_DATA = 1'b1
    } phase_t;
endpackage

// File: rtl/sbw_ctrl.sv
// Module: sbw_ctrl
// Sequences one sector: counts header and data bytes, latches the write
// decision on the first header byte, forms buffer write addresses and
// issues the done/consumed pulse. Assumes blk_ptr is the pre-advance value
// while the first header byte is being taken.
module sbw_ctrl
    import sbw_pkg::*;
#(
    parameter int P_HDR   = HDR_BYTES,
    parameter int P_DATA  = DATA_BYTES,
    parameter int P_STEP  = RAW_STEP,
    parameter int P_AW    = BUF_AW,
    parameter int P_PW    = PTR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dec_en,
    input  logic              wr_req,
    input  logic              s_valid,
    output logic              s_ready,
    input  logic [P_PW-1:0]   blk_ptr,
    output logic              hdr_take,
    output logic              hdr_last,
    output logic              first_wr,
    output logic              ram_we,
    output logic [P_AW-1:0]   ram_addr,
    output logic              done,
    output logic              consumed
);
    localparam int SEC_BYTES = P_HDR + P_DATA;
    localparam int CNT_W     = $clog2(SEC_BYTES);

    phase_t            phase_q;
    logic [CNT_W-1:0]  idx_q;
    logic              wr_lat_q;
    logic [P_AW-1:0]   base_q;

    logic              take;
    logic              at_first;
    logic              wr_now;
    logic              data_last;
    logic [P_AW-1:0]   base_now;

    // Handshake and per-byte decode of the current position.
    always_comb begin
        s_ready   = (phase_q == PH_DATA) || dec_en;
        take      = s_valid && s_ready;
        at_first  = (phase_q == PH_HDR) && (idx_q == '0);
        wr_now    = at_first ? wr_req : wr_lat_q;
        base_now  = at_first ? P_AW'(blk_ptr + P_PW'(P_STEP)) : base_q;
        hdr_take  = take && (phase_q == PH_HDR);
        hdr_last  = hdr_take && (idx_q == CNT_W'(P_HDR - 1));
        data_last = take && (phase_q == PH_DATA) && (idx_q == CNT_W'(SEC_BYTES - 1));
        first_wr  = take && at_first && wr_req;
        ram_we    = take && wr_now;
        ram_addr  = base_now + P_AW'(idx_q);
    end

    // Phase, byte index, latched write decision and end-of-sector pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q  <= PH_HDR;
            idx_q    <= '0;
            wr_lat_q <= 1'b0;
            base_q   <= '0;
            done     <= 1'b0;
            consumed <= 1'b0;
        end else begin
            done     <= 1'b0;
            consumed <= 1'b0;
            if (take) begin
                if (at_first) begin
                    wr_lat_q <= wr_req;
                    base_q   <= base_now;
                end
                if (hdr_last) begin
                    if (wr_now) begin
                        phase_q <= PH_DATA;
                        idx_q   <= idx_q + 1'b1;
                    end else begin
                        idx_q    <= '0;
                        done     <= 1'b1;
                        consumed <= 1'b0;
                    end
                end else if (data_last) begin
                    phase_q  <= PH_HDR;
                    idx_q    <= '0;
                    done     <= 1'b1;
                    consumed <= 1'b1;
                end else begin
                    idx_q <= idx_q + 1'b1;
                end
            end
        end
    end

    // R7: the end-of-sector indication lasts a single cycle.
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11: the data phase never stalls the source.
    p_ready_data_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_DATA) |-> s_ready);
endmodule

// File: rtl/sbw_status.sv
// Module: sbw_status
// Holds the current header, block pointer, write address, valid status and
// decoder-pending flag. Assumes hdr_take strobes each header byte in order
// and hdr_last marks the final one.
module sbw_status
    import sbw_pkg::*;
#(
    parameter int P_HDR  = HDR_BYTES,
    parameter int P_STEP = RAW_STEP,
    parameter int P_PW   = PTR_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [7:0]           s_data,
    input  logic                 hdr_take,
    input  logic                 hdr_last,
    input  logic                 first_wr,
    input  logic                 ld_ptrs,
    input  logic [P_PW-1:0]      ld_blk_ptr,
    input  logic [P_PW-1:0]      ld_wr_addr,
    input  logic                 stat_ack,
    output logic [8*P_HDR-1:0]   cur_hdr,
    output logic [P_PW-1:0]      blk_ptr,
    output logic [P_PW-1:0]      wr_addr,
    output logic [7:0]           valid_stat,
    output logic                 dec_pend_n
);
    localparam int SH_W = 8 * (P_HDR - 1);
    localparam logic [7:0] STAT_IDLE = 8'h80;
    localparam logic [7:0] STAT_NEW  = 8'h00;

    logic [SH_W-1:0] sh_q;

    // Collect the leading header bytes, publish all of them on the last.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q    <= '0;
            cur_hdr <= (8*P_HDR)'(1);
        end else if (hdr_take) begin
            sh_q <= {sh_q[SH_W-9:0], s_data};
            if (hdr_last) begin
                cur_hdr <= {sh_q, s_data};
            end
        end
    end

    // Pointer advance on a stored sector, otherwise load from the registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blk_ptr <= '0;
            wr_addr <= '0;
        end else if (first_wr) begin
            blk_ptr <= blk_ptr + P_PW'(P_STEP);
            wr_addr <= wr_addr + P_PW'(P_STEP);
        end else if (ld_ptrs) begin
            blk_ptr <= ld_blk_ptr;
            wr_addr <= ld_wr_addr;
        end
    end

    // Status: a new header wins over an acknowledge at the same edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_stat <= STAT_IDLE;
            dec_pend_n <= 1'b1;
        end else if (hdr_last) begin
            valid_stat <= STAT_NEW;
            dec_pend_n <= 1'b0;
        end else if (stat_ack) begin
            valid_stat <= STAT_IDLE;
            dec_pend_n <= 1'b1;
        end
    end

    // R4 / R12: a stored sector advances both pointers by one raw step.
    p_ptr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        first_wr |=> (blk_ptr == P_PW'($past(blk_ptr) + P_PW'(P_STEP)))
                  && (wr_addr == P_PW'($past(wr_addr) + P_PW'(P_STEP))));

    // R3: header completion flags a new sector.
    p_valid_on_hdr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_last |=> (valid_stat == STAT_NEW) && !dec_pend_n);

    // R8: an acknowledge without a new header restores the idle status.
    p_ack_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_ack && !hdr_last) |=> (valid_stat == STAT_IDLE) && dec_pend_n);
endmodule

// File: rtl/sbw_lane_ram.sv
// Module: sbw_lane_ram
// One byte lane of the sector buffer: inferred RAM with one write port and
// one registered read port. Assumes no read-during-write ordering matters.
module sbw_lane_ram #(
    parameter int P_WAW = 12
) (
    input  logic              clk,
    input  logic              we,
    input  logic [P_WAW-1:0]  waddr,
    input  logic [7:0]        wdata,
    input  logic [P_WAW-1:0]  raddr,
    output logic [7:0]        rdata
);
    logic [7:0] mem [2**P_WAW];

    // Byte write and registered read.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/sector_buf_writer.sv
// Module: sector_buf_writer
// Top: stores incoming sectors into a circular byte buffer built from byte
// lanes, and exposes header, pointers and status to a register block.
// Assumes the source re-presents a sector when done arrives with consumed=0.
module sector_buf_writer
    import sbw_pkg::*;
#(
    parameter int P_HDR   = HDR_BYTES,
    parameter int P_DATA  = DATA_BYTES,
    parameter int P_STEP  = RAW_STEP,
    parameter int P_AW    = BUF_AW,
    parameter int P_PW    = PTR_W,
    parameter int P_LANES = LANES
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                dec_en,
    input  logic                wr_req,
    input  logic                s_valid,
    input  logic [7:0]          s_data,
    output logic                s_ready,
    input  logic                ld_ptrs,
    input  logic [P_PW-1:0]     ld_blk_ptr,
    input  logic [P_PW-1:0]     ld_wr_addr,
    input  logic                stat_ack,
    output logic                done,
    output logic                consumed,
    output logic [8*P_HDR-1:0]  cur_hdr,
    output logic [P_PW-1:0]     blk_ptr,
    output logic [P_PW-1:0]     wr_addr,
    output logic [7:0]          valid_stat,
    output logic                dec_pend_n,
    input  logic [P_AW-1:0]     rd_addr,
    output logic [7:0]          rd_data
);
    localparam int LANE_BITS = $clog2(P_LANES);
    localparam int WORD_AW   = P_AW - LANE_BITS;

    logic                  hdr_take;
    logic                  hdr_last;
    logic                  first_wr;
    logic                  ram_we;
    logic [P_AW-1:0]       ram_addr;
    logic [7:0]            lane_q [P_LANES];
    logic [LANE_BITS-1:0]  rd_sel_q;

    sbw_ctrl #(
        .P_HDR  (P_HDR),
        .P_DATA (P_DATA),
        .P_STEP (P_STEP),
        .P_AW   (P_AW),
        .P_PW   (P_PW)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .dec_en   (dec_en),
        .wr_req   (wr_req),
        .s_valid  (s_valid),
        .s_ready  (s_ready),
        .blk_ptr  (blk_ptr),
        .hdr_take (hdr_take),
        .hdr_last (hdr_last),
        .first_wr (first_wr),
        .ram_we   (ram_we),
        .ram_addr (ram_addr),
        .done     (done),
        .consumed (consumed)
    );

    sbw_status #(
        .P_HDR  (P_HDR),
        .P_STEP (P_STEP),
        .P_PW   (P_PW)
    ) u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .s_data     (s_data),
        .hdr_take   (hdr_take),
        .hdr_last   (hdr_last),
        .first_wr   (first_wr),
        .ld_ptrs    (ld_ptrs),
        .ld_blk_ptr (ld_blk_ptr),
        .ld_wr_addr (ld_wr_addr),
        .stat_ack   (stat_ack),
        .cur_hdr    (cur_hdr),
        .blk_ptr    (blk_ptr),
        .wr_addr    (wr_addr),
        .valid_stat (valid_stat),
        .dec_pend_n (dec_pend_n)
    );

    // One RAM per byte lane; the low address bits pick the lane.
    for (genvar g = 0; g < P_LANES; g++) begin : g_lane
        sbw_lane_ram #(
            .P_WAW (WORD_AW)
        ) u_ram (
            .clk   (clk),
            .we    (ram_we && (ram_addr[LANE_BITS-1:0] == LANE_BITS'(g))),
            .waddr (ram_addr[P_AW-1:LANE_BITS]),
            .wdata (s_data),
            .raddr (rd_addr[P_AW-1:LANE_BITS]),
            .rdata (lane_q[g])
        );
    end

    // Remember which lane the pending read targets.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_sel_q <= '0;
        end else begin
            rd_sel_q <= rd_addr[LANE_BITS-1:0];
        end
    end

    // Read data from the selected lane.
    always_comb begin
        rd_data = lane_q[rd_sel_q];
    end

    // R6: an unconsumed sector ends without a buffer write on its last byte.
    p_no_store_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !consumed) |-> !$past(ram_we));
endmodule

// File: tb/sector_buf_writer_bench.sv
module sector_buf_writer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dec_en = 1'b0;
    logic        wr_req = 1'b0;
    logic        s_valid = 1'b0;
    logic [7:0]  s_data = 8'h00;
    logic        s_ready;
    logic        ld_ptrs = 1'b0;
    logic [15:0] ld_blk_ptr = 16'h0;
    logic [15:0] ld_wr_addr = 16'h0;
    logic        stat_ack = 1'b0;
    logic        done;
    logic        consumed;
    logic [31:0] cur_hdr;
    logic [15:0] blk_ptr;
    logic [15:0] wr_addr;
    logic [7:0]  valid_stat;
    logic        dec_pend_n;
    logic [13:0] rd_addr = 14'h0;
    logic [7:0]  rd_data;

    always #4 clk = ~clk;

    sector_buf_writer u_sector_buf_writer (
        .clk        (clk),
        .rst_n      (rst_n),
        .dec_en     (dec_en),
        .wr_req     (wr_req),
        .s_valid    (s_valid),
        .s_data     (s_data),
        .s_ready    (s_ready),
        .ld_ptrs    (ld_ptrs),
        .ld_blk_ptr (ld_blk_ptr),
        .ld_wr_addr (ld_wr_addr),
        .stat_ack   (stat_ack),
        .done       (done),
        .consumed   (consumed),
        .cur_hdr    (cur_hdr),
        .blk_ptr    (blk_ptr),
        .wr_addr    (wr_addr),
        .valid_stat (valid_stat),
        .dec_pend_n (dec_pend_n),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data)
    );

    int n_chk  = 0;
    int n_fail = 0;

    localparam int STEP = 2352;
    localparam int SEC  = 2052;

    // Vector fields: write request, start block pointer, start write address,
    // sector seed, seed expected in the readback region.
    localparam int NV = 6;
    localparam logic [48:0] VEC [NV] = '{
        {1'b1, 16'h0000, 16'h0100, 8'h11, 8'h11},
        {1'b1, 16'h3000, 16'h0000, 8'h22, 8'h22},
        {1'b0, 16'h0000, 16'h5678, 8'h33, 8'h11},
        {1'b1, 16'hF800, 16'hFFFF, 8'h44, 8'h44},
        {1'b1, 16'h36D0, 16'h0123, 8'h55, 8'h55},
        {1'b1, 16'h06D0, 16'h4000, 8'h66, 8'h66}
    };

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] sbyte(input logic [7:0] seed, input int k);
        return seed + 8'(k * 7) + 8'(k >> 8);
    endfunction

    // Offers nbytes bytes; drops dec_en after byte drop_at when drop_at >= 0.
    task automatic send_sector(input logic [7:0] seed, input int nbytes, input int drop_at);
        for (int k = 0; k < nbytes; k++) begin
            @(negedge clk);
            s_valid = 1'b1;
            s_data  = sbyte(seed, k);
            if (drop_at >= 0 && k == drop_at) dec_en = 1'b0;
            if (drop_at >= 0 && k == drop_at + 100)
                check("R11", "ready in data phase with decode off", {31'b0, s_ready}, 32'd1);
            while (!s_ready) @(negedge clk);
            @(posedge clk);
        end
        @(negedge clk);
        s_valid = 1'b0;
    endtask

    task automatic check_region(input string req, input logic [13:0] base, input logic [7:0] seed);
        int bad = 0;
        logic [7:0] first_act = 8'h0;
        logic [7:0] first_exp = 8'h0;
        for (int k = 0; k < SEC; k++) begin
            @(negedge clk);
            rd_addr = base + 14'(k);
            @(negedge clk);
            if (rd_data !== sbyte(seed, k)) begin
                if (bad == 0) begin
                    first_act = rd_data;
                    first_exp = sbyte(seed, k);
                end
                bad++;
            end
        end
        check(req, "buffer region contents", {24'b0, first_act}, {24'b0, first_exp});
    endtask

    task automatic load_ptrs(input logic [15:0] pt, input logic [15:0] wa);
        @(negedge clk);
        ld_ptrs = 1'b1;
        ld_blk_ptr = pt;
        ld_wr_addr = wa;
        @(negedge clk);
        ld_ptrs = 1'b0;
    endtask

    task automatic ack_status();
        @(negedge clk);
        stat_ack = 1'b1;
        @(negedge clk);
        stat_ack = 1'b0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1", "cur_hdr", cur_hdr, 32'h0000_0001);
        check("R1", "valid_stat", {24'b0, valid_stat}, 32'h80);
        check("R1", "dec_pend_n", {31'b0, dec_pend_n}, 32'd1);
        check("R1", "blk_ptr", {16'b0, blk_ptr}, 32'h0);
        check("R1", "wr_addr", {16'b0, wr_addr}, 32'h0);
        check("R1", "done", {31'b0, done}, 32'd0);
        check("R1", "s_ready", {31'b0, s_ready}, 32'd0);

        // Vector table walk: R3 R4 R5 R6 R7 R9 R10 R12
        for (int i = 0; i < NV; i++) begin
            logic        v_wr;
            logic [15:0] v_pt;
            logic [15:0] v_wa;
            logic [7:0]  v_seed;
            logic [7:0]  v_rb;
            logic [15:0] e_pt;
            logic [15:0] e_wa;
            {v_wr, v_pt, v_wa, v_seed, v_rb} = VEC[i];
            e_pt = v_wr ? 16'(v_pt + 16'(STEP)) : v_pt;
            e_wa = v_wr ? 16'(v_wa + 16'(STEP)) : v_wa;
            load_ptrs(v_pt, v_wa);
            check("R9", "loaded blk_ptr", {16'b0, blk_ptr}, {16'b0, v_pt});
            check("R9", "loaded wr_addr", {16'b0, wr_addr}, {16'b0, v_wa});
            dec_en = 1'b1;
            wr_req = v_wr;
            send_sector(v_seed, v_wr ? SEC : 4, -1);
            check(v_wr ? "R7" : "R6", "done", {31'b0, done}, 32'd1);
            check(v_wr ? "R7" : "R6", "consumed", {31'b0, consumed}, {31'b0, v_wr});
            check("R4", "blk_ptr after sector (R12 wrap)", {16'b0, blk_ptr}, {16'b0, e_pt});
            check("R4", "wr_addr after sector (R12 wrap)", {16'b0, wr_addr}, {16'b0, e_wa});
            check("R3", "cur_hdr", cur_hdr,
                  {sbyte(v_seed, 0), sbyte(v_seed, 1), sbyte(v_seed, 2), sbyte(v_seed, 3)});
            check("R3", "valid_stat", {24'b0, valid_stat}, 32'h00);
            check("R3", "dec_pend_n", {31'b0, dec_pend_n}, 32'd0);
            @(negedge clk);
            check("R7", "done falls after one cycle", {31'b0, done}, 32'd0);
            ack_status();
            check("R8", "valid_stat after ack", {24'b0, valid_stat}, 32'h80);
            check("R8", "dec_pend_n after ack", {31'b0, dec_pend_n}, 32'd1);
            // R5 R10 stored bytes; R6 region left intact when not stored
            check_region(v_wr ? "R5" : "R6", 14'(16'(v_pt + 16'(STEP))), v_rb);
        end

        // R2: decode disabled holds the input and leaves all state alone
        dec_en = 1'b0;
        @(negedge clk);
        s_valid = 1'b1;
        s_data  = 8'hAA;
        begin
            int hi = 0;
            for (int c = 0; c < 10; c++) begin
                @(negedge clk);
                if (s_ready) hi++;
            end
            check("R2", "ready cycles with decode off", hi, 32'd0);
        end
        s_valid = 1'b0;
        check("R2", "blk_ptr unchanged", {16'b0, blk_ptr}, 32'h1000);
        check("R2", "cur_hdr unchanged", cur_hdr,
              {sbyte(8'h66, 0), sbyte(8'h66, 1), sbyte(8'h66, 2), sbyte(8'h66, 3)});
        check("R2", "valid_stat unchanged", {24'b0, valid_stat}, 32'h80);

        // R8: acknowledge during header completion loses, then takes effect
        dec_en = 1'b1;
        wr_req = 1'b0;
        stat_ack = 1'b1;
        send_sector(8'h99, 4, -1);
        check("R8", "header wins over ack", {24'b0, valid_stat}, 32'h00);
        @(negedge clk);
        check("R8", "ack applies next edge", {24'b0, valid_stat}, 32'h80);
        stat_ack = 1'b0;

        // R11: decode dropped in the data phase does not stall the sector
        load_ptrs(16'h2000, 16'h0000);
        dec_en = 1'b1;
        wr_req = 1'b1;
        send_sector(8'h77, SEC, 100);
        check("R11", "consumed after decode drop", {30'b0, done, consumed}, 32'd3);
        check_region("R11", 14'h2930, 8'h77);

        finish_run();
    end
endmodule